// File: doc/BRIEF.md
# Banked Debug Register Router

This block sits between a serial debug engine and a small set of internal access ports. It takes in one register request at a time. Each request carries a port/bank flag, a direction flag, two address bits and a 32-bit write word. The block does one of two things with it. It either serves the request from its own small debug-port register bank, or it forwards it as a single-cycle strobe on a parallel bus shared by up to `NUM_AP` access ports. Each request returns exactly one response word one cycle after it is accepted.

Addressing uses two levels. A sticky selection register holds the target port number and a 4-bit bank number. The two address bits in each request pick one of four words inside that bank, so the full 8-bit register address presented to the port is `{bank, a[1:0], 2'b00}`. Access-port reads are posted. The word returned for an access-port read is the result of the previous access-port read, which a read buffer holds. The debugger fetches the final result either with another access-port read or by reading the buffer directly.

Top module: `dp_ap_router`

## Requirements
- R1: After reset, the selection register, the control word and the read buffer are zero, and no response or strobe is active.
- R2: A debug-port write (`req_apndp_i`=0, `req_rnw_i`=0) with `req_addr_i`=2'b10 loads the selection register. A debug-port read of the same address returns it. No other request changes it.
- R3: An access-port request drives `ap_addr_o` = {selection bits [7:4], `req_addr_i`, 2'b00}. For example, bank 1 with address bits 2'b01 gives 0x14.
- R4: An access-port request to port number P (selection bits [31:24], P < `NUM_AP`) raises `ap_strobe_o` for exactly the cycle after acceptance. In that cycle `ap_sel_o` = 1<<P, `ap_write_o` = NOT `req_rnw_i`, and for writes `ap_wdata_o` carries the request's write word.
- R5: An access-port read responds with the read buffer's content from before the access. The port's data is sampled during the strobe cycle and becomes the new buffer content. The first read after reset therefore returns zero.
- R6: A debug-port read with `req_addr_i`=2'b11 returns the read buffer, including a result that completed in the same cycle, and causes no strobe.
- R7: A debug-port read with `req_addr_i`=2'b00 returns the constant `ID_VALUE`. Writes to addresses 2'b00 and 2'b11 have no effect.
- R8: Debug-port address 2'b01 reaches a read/write control word only when selection bits [3:0] are zero. With any other value there, it reads as zero and writes are ignored. Those bits do not affect other debug-port addresses.
- R9: An access-port request whose port number is `NUM_AP` or above raises no strobe and no select line. It still responds. A read of this kind loads zero into the read buffer.
- R10: Every accepted request gives `rsp_valid_o` high for one cycle in the next cycle. Debug-port requests never raise `ap_strobe_o`. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request accepted this cycle |
| req_apndp_i | input | 1 | 1 = access-port request, 0 = debug-port request |
| req_rnw_i | input | 1 | 1 = read, 0 = write |
| req_addr_i | input | 2 | Word address within the bank |
| req_wdata_i | input | 32 | Write word |
| rsp_valid_o | output | 1 | Response valid |
| rsp_rdata_o | output | 32 | Response read word |
| ap_sel_o | output | NUM_AP | One-hot port select |
| ap_strobe_o | output | 1 | Access strobe toward ports |
| ap_write_o | output | 1 | Strobed access is a write |
| ap_addr_o | output | 8 | Port register address |
| ap_wdata_o | output | 32 | Port write word |
| ap_rdata_i | input | 32*NUM_AP | Read words, port p in slice p |

## Verification
Every response, and every access-port strobe with its select, address and write word, is due one cycle after the request is taken. A port's read word enters the read buffer in the cycle after that. The bench drives each request at a falling edge and samples all outputs at the very next falling edge, with exactly one rising edge in between. It keeps its own model of the buffer, updated at the moment each access-port read completes, so a buffer read directly after an access-port read must see the freshly captured word.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned DW         = 32;
  localparam int unsigned AP_ADDR_W  = 8;
  localparam int unsigned APSEL_LSB  = 24;
  localparam int unsigned APSEL_W    = 8;
  localparam int unsigned APBANK_LSB = 4;
  localparam int unsigned APBANK_W   = 4;
  localparam int unsigned DPBANK_LSB = 0;
  localparam int unsigned DPBANK_W   = 4;

  typedef enum logic [1:0] {
    DP_ID    = 2'b00,
    DP_CTRL  = 2'b01,
    DP_SEL   = 2'b10,
    DP_RDBUF = 2'b11
  } dp_reg_e;

  typedef struct packed {
    logic [APSEL_W-1:0]  apsel;
    logic [APBANK_W-1:0] apbank;
    logic [DPBANK_W-1:0] dpbank;
  } sel_fields_t;

  function automatic sel_fields_t split_select(input logic [DW-1:0] s);
    sel_fields_t f;
    f.apsel  = s[APSEL_LSB +: APSEL_W];
    f.apbank = s[APBANK_LSB +: APBANK_W];
    f.dpbank = s[DPBANK_LSB +: DPBANK_W];
    return f;
  endfunction
endpackage

// File: rtl/dpr_dp_regs.sv
module dpr_dp_regs
  import dpr_pkg::*;
#(
  parameter logic [DW-1:0] ID_VALUE = 32'h0DB6_0001
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  dp_reg_e             reg_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [DW-1:0]       rdbuf_i,
  output logic [APSEL_W-1:0]  apsel_o,
  output logic [APBANK_W-1:0] apbank_o,
  output logic [DW-1:0]       rdata_o
);
  logic [DW-1:0] select_q;
  logic [DW-1:0] ctrl_q;
  sel_fields_t   fld;

  assign fld      = split_select(select_q);
  assign apsel_o  = fld.apsel;
  assign apbank_o = fld.apbank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      select_q <= '0;
      ctrl_q   <= '0;
    end else if (wr_i) begin
      unique case (reg_i)
        DP_SEL:  select_q <= wdata_i;
        DP_CTRL: if (fld.dpbank == '0) ctrl_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (reg_i)
      DP_ID:    rdata_o = ID_VALUE;
      DP_CTRL:  rdata_o = (fld.dpbank == '0) ? ctrl_q : '0;
      DP_SEL:   rdata_o = select_q;
      DP_RDBUF: rdata_o = rdbuf_i;
      default:  rdata_o = '0;
    endcase
  end

  p_select_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && reg_i == DP_SEL) |=> $stable(select_q));

  p_ctrl_bank_guard_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && reg_i == DP_CTRL && fld.dpbank != '0) |=> $stable(ctrl_q));
endmodule

// File: rtl/dpr_ap_bus.sv
module dpr_ap_bus
  import dpr_pkg::*;
#(
  parameter int unsigned NUM_AP = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 go_i,
  input  logic                 rnw_i,
  input  logic [APSEL_W-1:0]   apsel_i,
  input  logic [APBANK_W-1:0]  bank_i,
  input  logic [1:0]           a_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [NUM_AP*DW-1:0] ap_rdata_i,
  output logic [NUM_AP-1:0]    ap_sel_o,
  output logic                 ap_strobe_o,
  output logic                 ap_write_o,
  output logic [AP_ADDR_W-1:0] ap_addr_o,
  output logic [DW-1:0]        ap_wdata_o,
  output logic                 rd_done_o,
  output logic [DW-1:0]        rd_data_o
);
  logic [NUM_AP-1:0]    hit_vec;
  logic [NUM_AP-1:0]    sel_q;
  logic                 strobe_q, write_q, rdpend_q;
  logic [AP_ADDR_W-1:0] addr_q;
  logic [DW-1:0]        wdata_q;
  logic [DW-1:0]        lane [NUM_AP];

  for (genvar p = 0; p < NUM_AP; p++) begin : g_port
    assign hit_vec[p] = (apsel_i == APSEL_W'(p));
    assign lane[p]    = sel_q[p] ? ap_rdata_i[p*DW +: DW] : '0;
  end

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < NUM_AP; p++) rd_data_o |= lane[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= '0;
      strobe_q <= 1'b0;
      write_q  <= 1'b0;
      rdpend_q <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      sel_q    <= go_i ? hit_vec : '0;
      strobe_q <= go_i && (|hit_vec);
      rdpend_q <= go_i && rnw_i;
      if (go_i) begin
        write_q <= !rnw_i;
        addr_q  <= {bank_i, a_i, 2'b00};
        if (!rnw_i) wdata_q <= wdata_i;
      end
    end
  end

  assign ap_sel_o    = sel_q;
  assign ap_strobe_o = strobe_q;
  assign ap_write_o  = write_q;
  assign ap_addr_o   = addr_q;
  assign ap_wdata_o  = wdata_q;
  assign rd_done_o   = rdpend_q;

  p_strobe_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_strobe_o |-> $countones(ap_sel_o) == 1);

  p_strobe_origin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_strobe_o |-> $past(go_i));

  p_no_sel_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ap_strobe_o |-> ap_sel_o == '0);
endmodule

// File: rtl/dpr_rdbuf.sv
module dpr_rdbuf
  import dpr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] value_o
);
  logic [DW-1:0] buf_q;

  // bypass so a result completing now is visible to this cycle's request
  assign value_o = load_i ? data_i : buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     buf_q <= '0;
    else if (load_i) buf_q <= data_i;
  end
endmodule

// File: rtl/dp_ap_router.sv
module dp_ap_router
  import dpr_pkg::*;
#(
  parameter int unsigned   NUM_AP   = 4,
  parameter logic [31:0]   ID_VALUE = 32'h0DB6_0001
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 req_apndp_i,
  input  logic                 req_rnw_i,
  input  logic [1:0]           req_addr_i,
  input  logic [31:0]          req_wdata_i,
  output logic                 rsp_valid_o,
  output logic [31:0]          rsp_rdata_o,
  output logic [NUM_AP-1:0]    ap_sel_o,
  output logic                 ap_strobe_o,
  output logic                 ap_write_o,
  output logic [7:0]           ap_addr_o,
  output logic [31:0]          ap_wdata_o,
  input  logic [NUM_AP*32-1:0] ap_rdata_i
);
  logic                dp_go, ap_go;
  logic [APSEL_W-1:0]  apsel;
  logic [APBANK_W-1:0] apbank;
  logic [DW-1:0]       dp_rdata, rdbuf_val, rd_data;
  logic                rd_done;
  logic                rsp_valid_q;
  logic [DW-1:0]       rsp_rdata_q;

  assign dp_go = req_valid_i && !req_apndp_i;
  assign ap_go = req_valid_i &&  req_apndp_i;

  dpr_dp_regs #(.ID_VALUE(ID_VALUE)) u_dp_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (dp_go && !req_rnw_i),
    .reg_i    (dp_reg_e'(req_addr_i)),
    .wdata_i  (req_wdata_i),
    .rdbuf_i  (rdbuf_val),
    .apsel_o  (apsel),
    .apbank_o (apbank),
    .rdata_o  (dp_rdata)
  );

  dpr_ap_bus #(.NUM_AP(NUM_AP)) u_ap_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (ap_go),
    .rnw_i       (req_rnw_i),
    .apsel_i     (apsel),
    .bank_i      (apbank),
    .a_i         (req_addr_i),
    .wdata_i     (req_wdata_i),
    .ap_rdata_i  (ap_rdata_i),
    .ap_sel_o    (ap_sel_o),
    .ap_strobe_o (ap_strobe_o),
    .ap_write_o  (ap_write_o),
    .ap_addr_o   (ap_addr_o),
    .ap_wdata_o  (ap_wdata_o),
    .rd_done_o   (rd_done),
    .rd_data_o   (rd_data)
  );

  dpr_rdbuf u_rdbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rd_done),
    .data_i  (rd_data),
    .value_o (rdbuf_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      if (req_valid_i)
        rsp_rdata_q <= !req_rnw_i ? '0 : (req_apndp_i ? rdbuf_val : dp_rdata);
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  p_rsp_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_dp_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_apndp_i) |=> !ap_strobe_o);

  p_id_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_apndp_i && req_rnw_i && req_addr_i == 2'b00)
      |=> rsp_rdata_o == ID_VALUE);
endmodule

// File: tb/dp_ap_router_tb_top.sv
module dp_ap_router_tb_top;
  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned NUM_AP     = 4;
  localparam logic [31:0] ID_VALUE   = 32'h0DB6_0001;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 req_valid, req_apndp, req_rnw;
  logic [1:0]           req_addr;
  logic [31:0]          req_wdata;
  logic                 rsp_valid;
  logic [31:0]          rsp_rdata;
  logic [NUM_AP-1:0]    ap_sel;
  logic                 ap_strobe, ap_write;
  logic [7:0]           ap_addr;
  logic [31:0]          ap_wdata;
  logic [NUM_AP*32-1:0] ap_rdata;

  int   n_tests = 0;
  int   n_fail  = 0;
  logic done    = 1'b0;
  logic [31:0] exp_rdbuf = '0;

  logic                 g_valid, g_strobe, g_write;
  logic [31:0]          g_rdata, g_wdata;
  logic [NUM_AP-1:0]    g_sel;
  logic [7:0]           g_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_ap_router #(.NUM_AP(NUM_AP), .ID_VALUE(ID_VALUE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_apndp_i(req_apndp), .req_rnw_i(req_rnw),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .ap_sel_o(ap_sel), .ap_strobe_o(ap_strobe), .ap_write_o(ap_write),
    .ap_addr_o(ap_addr), .ap_wdata_o(ap_wdata), .ap_rdata_i(ap_rdata)
  );

  function automatic logic [31:0] ap_word(input int p, input logic [7:0] a);
    return {8'(8'hC0 + p), 8'h3C, ~a, a};
  endfunction

  always_comb
    for (int p = 0; p < NUM_AP; p++) ap_rdata[p*32 +: 32] = ap_word(p, ap_addr);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic xfer(input logic apndp, input logic rnw, input logic [1:0] a,
                      input logic [31:0] wd);
    req_valid = 1'b1; req_apndp = apndp; req_rnw = rnw; req_addr = a; req_wdata = wd;
    @(negedge clk);
    g_valid = rsp_valid; g_rdata = rsp_rdata; g_strobe = ap_strobe;
    g_write = ap_write;  g_sel   = ap_sel;    g_addr   = ap_addr; g_wdata = ap_wdata;
    req_valid = 1'b0;
    check("R10 rsp_valid", 32'(g_valid), 32'd1);
    if (!apndp) check("R10 dp no strobe", 32'(g_strobe), 32'd0);
    if (!rnw)   check("R10 write rsp zero", g_rdata, 32'd0);
  endtask

  task automatic set_sel(input int p, input int bank, input int dpbank);
    xfer(1'b0, 1'b0, 2'b10, {8'(p), 16'h0, 4'(bank), 4'(dpbank)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_apndp = 1'b0; req_rnw = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    check("R1 strobe in reset", 32'(ap_strobe), 32'd0);
    check("R1 sel in reset", 32'(ap_sel), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle no rsp", 32'(rsp_valid), 32'd0);

    xfer(1'b0, 1'b1, 2'b10, '0); check("R1 select reset", g_rdata, 32'd0);
    xfer(1'b0, 1'b1, 2'b01, '0); check("R1 ctrl reset", g_rdata, 32'd0);
    xfer(1'b1, 1'b1, 2'b00, '0); check("R5 first read stale zero", g_rdata, 32'd0);
    check("R4 strobe port0", 32'(g_strobe), 32'd1);
    exp_rdbuf = ap_word(0, 8'h00);
    xfer(1'b0, 1'b1, 2'b11, '0); check("R6 rdbuf bypass", g_rdata, exp_rdbuf);

    xfer(1'b0, 1'b1, 2'b00, '0); check("R7 id", g_rdata, ID_VALUE);
    xfer(1'b0, 1'b0, 2'b00, 32'hDEAD_BEEF);
    xfer(1'b0, 1'b1, 2'b00, '0); check("R7 id after write", g_rdata, ID_VALUE);
    xfer(1'b0, 1'b0, 2'b11, 32'h1234_5678);
    xfer(1'b0, 1'b1, 2'b11, '0); check("R7 rdbuf write ignored", g_rdata, exp_rdbuf);

    xfer(1'b0, 1'b0, 2'b01, 32'hA5A5_1234);
    xfer(1'b0, 1'b1, 2'b01, '0); check("R8 ctrl bank0 rw", g_rdata, 32'hA5A5_1234);
    set_sel(0, 0, 3);
    xfer(1'b0, 1'b1, 2'b01, '0); check("R8 other bank reads zero", g_rdata, 32'd0);
    xfer(1'b0, 1'b0, 2'b01, 32'hFFFF_0000);
    xfer(1'b0, 1'b1, 2'b00, '0); check("R8 bank ignored at id", g_rdata, ID_VALUE);
    xfer(1'b0, 1'b1, 2'b10, '0); check("R2 select readback", g_rdata, 32'h0000_0003);
    xfer(1'b0, 1'b1, 2'b11, '0); check("R8 bank ignored at rdbuf", g_rdata, exp_rdbuf);
    set_sel(0, 0, 0);
    xfer(1'b0, 1'b1, 2'b01, '0); check("R8 ctrl kept", g_rdata, 32'hA5A5_1234);

    for (int p = 0; p < NUM_AP + 2; p++) begin
      for (int b = 0; b < 16; b++) begin
        set_sel(p, b, 0);
        xfer(1'b0, 1'b1, 2'b10, '0);
        check("R2 select sweep", g_rdata, {8'(p), 16'h0, 4'(b), 4'h0});
        for (int a = 0; a < 4; a++) begin
          logic [31:0] wd;
          logic [7:0]  ea;
          logic        mapped;
          mapped = (p < NUM_AP);
          ea = {4'(b), 2'(a), 2'b00};
          wd = {8'(p), 8'(b), 8'(a), 8'h5E};
          xfer(1'b1, 1'b0, 2'(a), wd);
          check(mapped ? "R4 write strobe" : "R9 write dropped", 32'(g_strobe), 32'(mapped));
          check(mapped ? "R4 write sel" : "R9 no sel", 32'(g_sel),
                mapped ? 32'(1 << p) : 32'd0);
          if (mapped) begin
            check("R3 write addr", 32'(g_addr), 32'(ea));
            check("R4 write flag", 32'(g_write), 32'd1);
            check("R4 write data", g_wdata, wd);
          end
          xfer(1'b1, 1'b1, 2'(a), '0);
          check("R5 posted read data", g_rdata, exp_rdbuf);
          check(mapped ? "R4 read strobe" : "R9 read no strobe", 32'(g_strobe), 32'(mapped));
          if (mapped) begin
            check("R3 read addr", 32'(g_addr), 32'(ea));
            check("R4 read flag", 32'(g_write), 32'd0);
          end
          exp_rdbuf = mapped ? ap_word(p, ea) : 32'd0;
        end
        xfer(1'b0, 1'b1, 2'b11, '0);
        check(p < NUM_AP ? "R6 rdbuf sweep" : "R9 rdbuf zero", g_rdata, exp_rdbuf);
      end
    end

    set_sel(2, 1, 0);
    xfer(1'b1, 1'b1, 2'b01, '0);
    check("R3 bank1 a01 addr 0x14", 32'(g_addr), 32'h14);
    check("R5 read after sweep", g_rdata, exp_rdbuf);
    xfer(1'b1, 1'b1, 2'b10, '0);
    check("R5 back-to-back read", g_rdata, ap_word(2, 8'h14));
    xfer(1'b1, 1'b1, 2'b11, '0);
    check("R5 back-to-back read 2", g_rdata, ap_word(2, 8'h18));
    exp_rdbuf = ap_word(2, 8'h1C);
    @(negedge clk);
    check("R10 idle after burst", 32'(rsp_valid), 32'd0);
    xfer(1'b0, 1'b1, 2'b11, '0);
    check("R6 rdbuf after gap", g_rdata, exp_rdbuf);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule